// File: doc/BRIEF.md
# External Conversion Trigger Selector

This block sits in front of the sequencer of a multi-channel converter controller and decides which external event may start a conversion. It picks one candidate signal, either the digital level of one of the analog-pin inputs or one of a small set of dedicated trigger inputs. It passes that signal through a synchronizer and turns it into a start request according to one of four sensitivity modes: falling edge, rising edge, low level or high level.

The source-select bit chooses between the two families of inputs, and a 4-bit channel code picks the member. The dedicated family has fewer members than the code can name, so the spare codes are flagged as reserved and can never start a conversion. If the dedicated inputs are not built into the chip, the select bit is ignored and the code always names a pin. While the trigger is enabled and a pin is the source, that pin's digital input buffer is switched on so its level can be read.

When the enable, source, code or sensitivity setting changes, the detector waits until the synchronizer holds only samples of the new source. A settings write therefore cannot produce a start by itself.

Top module: `ext_trig_sel`

## Requirements
- R1: With `src_sel`=0, the source is `pin_lvl[chan_code]`.
- R2: With `src_sel`=1 and `chan_code` below `N_DED` (0 to 3 by default), the source is `ded_trig[chan_code]`. Code 2 selects input 2 and code 3 selects input 3.
- R3: With `src_sel`=1 and `chan_code` of `N_DED` or more (0b01xx and 0b1xxx by default), `code_rsvd` is 1, `pin_ibuf_en` is all zero, and `start_req` and `level_active` stay 0.
- R4: With `HAS_DED`=0, `src_sel` has no effect. `code_rsvd` is 0 and the source and buffer enable follow `chan_code` as in R1 and R6.
- R5: With `trig_en`=0, `start_req`, `level_active` and `pin_ibuf_en` are all 0 whatever the inputs do.
- R6: `pin_ibuf_en` has bit `chan_code` set, and no other bit, exactly when `trig_en`=1 and a pin is the source. Otherwise it is zero. The output is combinational.
- R7: In edge mode (`sense_level`=0), a change of the source to the active value (1 when `sense_pol`=1, 0 when `sense_pol`=0) gives a `start_req` pulse one cycle wide. It is visible after the third rising clock edge that samples the new value. A change to the inactive value gives no pulse.
- R8: In level mode (`sense_level`=1), `start_req` is 1 for as long as the synchronized source equals `sense_pol`, with the same three-edge latency.
- R9: In either mode, `level_active` is 1 exactly when the trigger is enabled, the code is not reserved and the synchronized source equals `sense_pol`.
- R10: After any change of `trig_en`, `src_sel`, `chan_code`, `sense_level` or `sense_pol`, detection is held off until the synchronizer holds only the new source. In edge mode, such a change alone never produces a pulse.
- R11: Activity on pins and dedicated inputs that are not selected does not change `start_req` or `level_active`.
- R12: During and right after reset, `start_req` and `level_active` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_en | input | 1 | External trigger enable |
| src_sel | input | 1 | 0: analog-pin family, 1: dedicated family |
| chan_code | input | 4 | Member of the chosen family |
| pin_lvl | input | N_PIN | Digital levels of the analog pins |
| ded_trig | input | N_DED | Dedicated trigger inputs |
| sense_level | input | 1 | 0: edge sensitive, 1: level sensitive |
| sense_pol | input | 1 | 1: rising/high, 0: falling/low |
| start_req | output | 1 | Start-of-conversion request |
| level_active | output | 1 | Synchronized source at its active value |
| code_rsvd | output | 1 | Reserved code selected |
| pin_ibuf_en | output | N_PIN | Per-pin digital input buffer enable |

## Verification
Seeded random trials draw the enable, select bit, code and sensitivity mode. Each trial first holds the new settings, which shows whether a settings change alone leaks a start. It then flips only the selected source, which separates the pulse timing of the edge modes from the held output of the level modes and shows whether the right family member was picked. Last, it flips only unselected inputs, which exposes a mux that reads a neighbour. Directed cases cover the last dedicated code, the first reserved code, the top pin code and a long held level, and a second instance built without dedicated inputs shows whether the select bit is really ignored.

// File: rtl/ets_pkg.sv
package ets_pkg;

    localparam int CODE_W = 4;

    // bit 1: level sensitive, bit 0: active value
    typedef enum logic [1:0] {
        SENSE_FALL = 2'b00,
        SENSE_RISE = 2'b01,
        SENSE_LOW  = 2'b10,
        SENSE_HIGH = 2'b11
    } sense_e;

    typedef struct packed {
        logic              en;
        logic              src;
        logic [CODE_W-1:0] code;
        sense_e            mode;
    } cfg_t;

    function automatic logic mode_is_level(sense_e m);
        return m[1];
    endfunction

    function automatic logic mode_pol(sense_e m);
        return m[0];
    endfunction

endpackage

// File: rtl/ets_src_mux.sv
module ets_src_mux
    import ets_pkg::*;
#(
    parameter int N_PIN   = 16,
    parameter int N_DED   = 4,
    parameter bit HAS_DED = 1'b1
) (
    input  cfg_t             cfg_i,
    input  logic [N_PIN-1:0] pin_i,
    input  logic [N_DED-1:0] ded_i,
    output logic             raw_o,
    output logic             valid_o,
    output logic             rsvd_o,
    output logic [N_PIN-1:0] ibuf_o
);

    logic use_ded;
    assign use_ded = (HAS_DED != 1'b0) && cfg_i.src;

    always_comb begin
        raw_o   = 1'b0;
        valid_o = 1'b0;
        rsvd_o  = 1'b0;
        if (use_ded) begin
            rsvd_o = 1'b1;
            for (int i = 0; i < N_DED; i++) begin
                if (cfg_i.code == CODE_W'(i)) begin
                    raw_o   = ded_i[i];
                    valid_o = 1'b1;
                    rsvd_o  = 1'b0;
                end
            end
        end else begin
            for (int i = 0; i < N_PIN; i++) begin
                if (cfg_i.code == CODE_W'(i)) begin
                    raw_o   = pin_i[i];
                    valid_o = 1'b1;
                end
            end
        end
    end

    // one buffer-enable decoder per pin
    for (genvar g = 0; g < N_PIN; g++) begin : g_ibuf
        assign ibuf_o[g] = cfg_i.en && !use_ded && (cfg_i.code == CODE_W'(g));
    end

endmodule

// File: rtl/ets_sync.sv
module ets_sync
    import ets_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    input  cfg_t cfg_i,
    output logic sync_o,
    output logic prev_o,
    output logic armed_o
);

    localparam int HOLD_W = $clog2(STAGES + 1);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
        cfg_t              cfg;
        logic [HOLD_W-1:0] hold;
    } sync_st_t;

    sync_st_t st_d, st_q;
    logic     cfg_chg;

    always_comb begin
        st_d       = st_q;
        cfg_chg    = (cfg_i != st_q.cfg);
        st_d.chain = {st_q.chain[STAGES-2:0], raw_i};
        st_d.prev  = st_q.chain[STAGES-1];
        st_d.cfg   = cfg_i;
        if (cfg_chg) begin
            st_d.hold = HOLD_W'(STAGES);
        end else if (st_q.hold != '0) begin
            st_d.hold = st_q.hold - HOLD_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.chain <= '0;
            st_q.prev  <= 1'b0;
            st_q.cfg   <= '0;
            st_q.hold  <= HOLD_W'(STAGES);
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o  = st_q.chain[STAGES-1];
    assign prev_o  = st_q.prev;
    assign armed_o = (st_q.hold == '0) && !cfg_chg;

    AST_CHG_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_chg |=> !armed_o); // R10

endmodule

// File: rtl/ets_cond.sv
module ets_cond
    import ets_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sync_i,
    input  logic   prev_i,
    input  logic   armed_i,
    input  logic   valid_i,
    input  logic   en_i,
    input  sense_e mode_i,
    output logic   start_o,
    output logic   lvl_o
);

    typedef struct packed {
        logic start;
        logic lvl;
    } cond_st_t;

    cond_st_t st_d, st_q;
    logic     live, at_lvl, edge_hit;

    always_comb begin
        live     = en_i && valid_i && armed_i;
        at_lvl   = (sync_i == mode_pol(mode_i));
        edge_hit = mode_pol(mode_i) ? (sync_i && !prev_i) : (!sync_i && prev_i);
        st_d.lvl   = live && at_lvl;
        st_d.start = live && (mode_is_level(mode_i) ? at_lvl : edge_hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign start_o = st_q.start;
    assign lvl_o   = st_q.lvl;

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.start && !mode_is_level(mode_i)) |=> !st_q.start); // R7
    AST_UNARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_i |=> (!st_q.start && !st_q.lvl)); // R10

endmodule

// File: rtl/ext_trig_sel.sv
module ext_trig_sel
    import ets_pkg::*;
#(
    parameter int N_PIN       = 16,
    parameter int N_DED       = 4,
    parameter bit HAS_DED     = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_en,
    input  logic              src_sel,
    input  logic [CODE_W-1:0] chan_code,
    input  logic [N_PIN-1:0]  pin_lvl,
    input  logic [N_DED-1:0]  ded_trig,
    input  logic              sense_level,
    input  logic              sense_pol,
    output logic              start_req,
    output logic              level_active,
    output logic              code_rsvd,
    output logic [N_PIN-1:0]  pin_ibuf_en
);

    cfg_t cfg;
    logic raw, valid, sync_v, prev_v, armed;

    always_comb begin
        cfg.en   = trig_en;
        cfg.src  = src_sel;
        cfg.code = chan_code;
        cfg.mode = sense_e'({sense_level, sense_pol});
    end

    ets_src_mux #(.N_PIN(N_PIN), .N_DED(N_DED), .HAS_DED(HAS_DED)) mux_i (
        .cfg_i  (cfg),
        .pin_i  (pin_lvl),
        .ded_i  (ded_trig),
        .raw_o  (raw),
        .valid_o(valid),
        .rsvd_o (code_rsvd),
        .ibuf_o (pin_ibuf_en)
    );

    ets_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (raw),
        .cfg_i  (cfg),
        .sync_o (sync_v),
        .prev_o (prev_v),
        .armed_o(armed)
    );

    ets_cond cond_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (sync_v),
        .prev_i (prev_v),
        .armed_i(armed),
        .valid_i(valid),
        .en_i   (trig_en),
        .mode_i (cfg.mode),
        .start_o(start_req),
        .lvl_o  (level_active)
    );

    AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        code_rsvd |=> (!start_req && !level_active)); // R3
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_en |=> (!start_req && !level_active)); // R5
    AST_IBUF_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pin_ibuf_en)); // R6

endmodule

// File: tb/ext_trig_sel_tb.sv
module ext_trig_sel_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig_en = 1'b0, src_sel = 1'b0, sense_level = 1'b0, sense_pol = 1'b0;
    logic [3:0]  chan_code = '0;
    logic [15:0] pin_lvl = '0;
    logic [3:0]  ded_trig = '0;
    logic        start_req, level_active, code_rsvd;
    logic [15:0] pin_ibuf_en;
    logic        nd_start, nd_lvl, nd_rsvd;
    logic [15:0] nd_ibuf;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ext_trig_sel dut_i (
        .clk(clk), .rst_n(rst_n), .trig_en(trig_en), .src_sel(src_sel),
        .chan_code(chan_code), .pin_lvl(pin_lvl), .ded_trig(ded_trig),
        .sense_level(sense_level), .sense_pol(sense_pol),
        .start_req(start_req), .level_active(level_active),
        .code_rsvd(code_rsvd), .pin_ibuf_en(pin_ibuf_en)
    );

    ext_trig_sel #(.HAS_DED(1'b0)) dut_nd_i (
        .clk(clk), .rst_n(rst_n), .trig_en(trig_en), .src_sel(src_sel),
        .chan_code(chan_code), .pin_lvl(pin_lvl), .ded_trig(ded_trig),
        .sense_level(sense_level), .sense_pol(sense_pol),
        .start_req(nd_start), .level_active(nd_lvl),
        .code_rsvd(nd_rsvd), .pin_ibuf_en(nd_ibuf)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit f_valid(bit has, bit src, logic [3:0] code);
        if (has && src) return code < 4'd4;
        return 1'b1;
    endfunction

    function automatic bit f_raw(bit has, bit src, logic [3:0] code, logic [15:0] p, logic [3:0] d);
        if (has && src) return (code < 4'd4) ? d[code[1:0]] : 1'b0;
        return p[code];
    endfunction

    function automatic logic [15:0] f_ibuf(bit has, bit en, bit src, logic [3:0] code);
        if (!en || (has && src)) return 16'h0;
        return 16'h1 << code;
    endfunction

    function automatic bit f_act(bit en, bit vld, bit raw, bit pol);
        return en && vld && (raw == pol);
    endfunction

    task automatic run_trial(bit en, bit src, logic [3:0] code, bit lvl, bit pol);
        bit vld, v, nv, a, na;
        string lbl;
        int fs;
        @(negedge clk);
        trig_en = en; src_sel = src; chan_code = code;
        sense_level = lvl; sense_pol = pol;
        pin_lvl = 16'($urandom); ded_trig = 4'($urandom);
        fs = 0;
        for (int i = 0; i < 5; i++) begin
            @(posedge clk); @(negedge clk);
            if (!lvl && start_req) fs++;
        end
        if (!lvl) chk("R10 start from settings change", fs, 0);
        vld = f_valid(1'b1, src, code);
        lbl = !en ? "R5" : (!vld ? "R3" : (src ? "R2" : "R1"));
        chk("R3 reserved flag", code_rsvd, 32'(src && code >= 4'd4));
        chk($sformatf("R6 buffer enable %s", lbl), pin_ibuf_en, f_ibuf(1'b1, en, src, code));
        v = f_raw(1'b1, src, code, pin_lvl, ded_trig);
        a = f_act(en, vld, v, pol);
        chk($sformatf("R9 level_active %s", lbl), level_active, a);
        chk($sformatf("R8 steady start %s", lbl), start_req, lvl ? a : 1'b0);
        chk("R4 reserved flag absent", nd_rsvd, 0);
        chk("R4 buffer enable", nd_ibuf, f_ibuf(1'b0, en, src, code));
        chk("R4 level_active", nd_lvl, f_act(en, 1'b1, f_raw(1'b0, src, code, pin_lvl, ded_trig), pol));
        // flip only the selected source
        if (src && code < 4'd4) ded_trig[code[1:0]] = ~ded_trig[code[1:0]];
        else if (!src) pin_lvl[code] = ~pin_lvl[code];
        else pin_lvl[code] = ~pin_lvl[code];
        nv = f_raw(1'b1, src, code, pin_lvl, ded_trig);
        na = f_act(en, vld, nv, pol);
        for (int i = 1; i <= 5; i++) begin
            bit el, es;
            @(posedge clk); @(negedge clk);
            el = (i >= 3) ? na : a;
            es = lvl ? el : (i == 3 && na && !a);
            chk($sformatf("%s start cycle %0d %s", lvl ? "R8" : "R7", i, lbl), start_req, es);
            chk($sformatf("R9 level_active cycle %0d %s", i, lbl), level_active, el);
        end
        // flip only unselected inputs
        pin_lvl[code + 4'd1] = ~pin_lvl[code + 4'd1];
        ded_trig[code[1:0] + 2'd1] = ~ded_trig[code[1:0] + 2'd1];
        for (int i = 1; i <= 5; i++) begin
            @(posedge clk); @(negedge clk);
            chk("R11 unselected start", start_req, lvl ? na : 1'b0);
            chk("R11 unselected level_active", level_active, na);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R12 start in reset", start_req, 0);
        chk("R12 level_active in reset", level_active, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 start after reset", start_req, 0);
        chk("R12 level_active after reset", level_active, 0);
        // directed corners
        run_trial(1'b1, 1'b1, 4'd3, 1'b0, 1'b1);
        run_trial(1'b1, 1'b1, 4'd2, 1'b0, 1'b0);
        run_trial(1'b1, 1'b1, 4'd0, 1'b1, 1'b1);
        run_trial(1'b1, 1'b1, 4'd4, 1'b1, 1'b0);
        run_trial(1'b1, 1'b1, 4'd8, 1'b0, 1'b1);
        run_trial(1'b1, 1'b0, 4'd15, 1'b1, 1'b1);
        run_trial(1'b0, 1'b0, 4'd5, 1'b1, 1'b0);
        // long held level
        @(negedge clk);
        trig_en = 1'b1; src_sel = 1'b0; chan_code = 4'd6;
        sense_level = 1'b1; sense_pol = 1'b1; pin_lvl[6] = 1'b1;
        repeat (5) @(negedge clk);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            chk("R8 held level keeps start", start_req, 1);
        end
        // random trials
        for (int t = 0; t < 60; t++) begin
            run_trial(($urandom % 4) != 0, 1'($urandom), 4'($urandom), 1'($urandom), 1'($urandom));
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule